// File: doc/BRIEF.md
# Condition-Register Branch Unit

This block carries out the branch class of a 16-bit stack-machine instruction set. The machine keeps no condition flags. The result of the previous instruction stays in a single last-result register, and a branch decides by looking at that value. The value is either NIL, or it carries a 5-bit type tag that marks whether it is a list. The surrounding core reduces the value to two inputs: a NIL flag and the type tag. It pulses a start strobe together with the branch word and the address of that word.

Most branches carry a 9-bit two's-complement displacement. The displacement counts from the word after the branch, so a displacement of zero simply falls through to the next word. The all-ones displacement cannot be a useful target, because it would point back at the branch itself. That value is therefore an escape. When it appears, the block reads the next word through a small fetch port and uses it as a 16-bit displacement, counted from the word after that extension. Two of the conditions discard the top of the operand stack, but only when the branch falls through. Condition code 7 is rejected as illegal.

Top module: `brunit_top`

## Requirements
- R1: A word is a branch when bits 12:9 equal 4'b1100, which is opcode 12 or 28 in bits 13:9. Bits 15:13 are the condition code and bits 8:0 are the short displacement. A start on any other word produces no done_o and no fetch_req_o.
- R2: For a short branch, next_pc_o = pc_i + 1 + sign-extended displacement when the branch is taken, and pc_i + 1 when it is not. The result appears with done_o on the first clock edge after the start is sampled.
- R3: The branch is taken as follows, by condition code. Code 0 always. Code 1 or 3 when last_nil_i = 1. Code 2 or 4 when last_nil_i = 0. Code 5 when last_tag_i differs from LIST_TAG (default 5'd3). Code 6 when last_tag_i equals LIST_TAG.
- R4: pop_o goes high together with done_o only for codes 3 and 4 when the branch is not taken. In every other completion pop_o is low.
- R5: A displacement of 9'h1FF on a legal condition is a long branch. In the cycle after the start, fetch_req_o is high and fetch_addr_o = pc_i + 1. fetch_data_i is read in that same cycle (combinational read port).
- R6: For a long branch, next_pc_o = pc_i + 2 + fetch_data_i (as 16-bit two's complement) when taken, and pc_i + 2 when not taken. done_o is due on the second clock edge after the start.
- R7: Condition code 7 raises illegal_o together with done_o one edge after the start. next_pc_o then equals pc_i, no fetch is made even when the displacement is all ones, and pop_o stays low.
- R8: While reset is held and after it is released, done_o, pop_o, illegal_o and fetch_req_o are low.
- R9: done_o is a single-cycle pulse for each branch.
- R10: Program-counter arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Instruction word presented |
| word_i | input | 16 | Instruction word |
| pc_i | input | 16 | Address of the instruction word |
| last_nil_i | input | 1 | Last result is NIL |
| last_tag_i | input | 5 | Type tag of the last result |
| fetch_req_o | output | 1 | Extension word read request |
| fetch_addr_o | output | 16 | Extension word address |
| fetch_data_i | input | 16 | Extension word, same-cycle read data |
| done_o | output | 1 | Branch resolved (one-cycle pulse) |
| next_pc_o | output | 16 | Next program counter, valid with done_o |
| pop_o | output | 1 | Discard top of stack, valid with done_o |
| illegal_o | output | 1 | Illegal condition code, valid with done_o |

## Verification
Short and illegal branches complete on the first clock edge after the start is sampled. A long branch shows its fetch request in the cycle after the start and completes on the second edge. The bench drives each start on a falling edge and drops the strobe on the next falling edge. At that point it checks either the result (short) or the fetch address with done_o still low (long). For a long branch it checks the result one falling edge later. One further falling edge then confirms that done_o has dropped. The model memory returns the extension word only at the expected address, so a wrong fetch address shows up as a wrong next_pc_o.

// File: rtl/brunit_pkg.sv
package brunit_pkg;
  localparam int WORD_W   = 16;
  localparam int SHORT_W  = 9;
  localparam int COND_LSB = 13;
  localparam int OPC_LSB  = 9;
  localparam logic [3:0] BRANCH_OPC = 4'b1100;

  typedef enum logic [2:0] {
    C_ALWAYS     = 3'd0,
    C_NIL        = 3'd1,
    C_NOTNIL     = 3'd2,
    C_NIL_POP    = 3'd3,
    C_NOTNIL_POP = 3'd4,
    C_ATOM       = 3'd5,
    C_LIST       = 3'd6,
    C_BAD        = 3'd7
  } cond_e;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_EXT  = 1'b1
  } state_e;

  typedef struct packed {
    logic taken;
    logic pop;
    logic bad;
  } verdict_t;
endpackage

// File: rtl/brunit_decode.sv
module brunit_decode
  import brunit_pkg::*;
(
  input  logic [WORD_W-1:0]  word_i,
  output cond_e              cond_o,
  output logic [SHORT_W-1:0] disp_o,
  output logic               is_branch_o,
  output logic               is_long_o
);
  logic [3:0] opc_low;

  always_comb begin
    opc_low     = word_i[OPC_LSB +: 4];
    cond_o      = cond_e'(word_i[COND_LSB +: 3]);
    disp_o      = word_i[SHORT_W-1:0];
    is_branch_o = (opc_low == BRANCH_OPC);
    is_long_o   = (&word_i[SHORT_W-1:0]);
  end
endmodule

// File: rtl/brunit_cond.sv
module brunit_cond
  import brunit_pkg::*;
#(
  parameter int TAG_W = 5,
  parameter logic [TAG_W-1:0] LIST_TAG = 5'd3
) (
  input  cond_e            cond_i,
  input  logic             nil_i,
  input  logic [TAG_W-1:0] tag_i,
  output verdict_t         verdict_o
);
  logic is_list;

  always_comb begin
    is_list   = (tag_i == LIST_TAG);
    verdict_o = '0;
    unique case (cond_i)
      C_ALWAYS:     verdict_o.taken = 1'b1;
      C_NIL:        verdict_o.taken = nil_i;
      C_NOTNIL:     verdict_o.taken = ~nil_i;
      C_NIL_POP:    begin verdict_o.taken = nil_i;  verdict_o.pop = ~nil_i; end
      C_NOTNIL_POP: begin verdict_o.taken = ~nil_i; verdict_o.pop = nil_i;  end
      C_ATOM:       verdict_o.taken = ~is_list;
      C_LIST:       verdict_o.taken = is_list;
      C_BAD:        verdict_o.bad   = 1'b1;
      default:      verdict_o.bad   = 1'b1;
    endcase
  end

  // R4: a pop request never accompanies a taken branch
  always_comb begin
    a_pop_excl_taken_r4: assert (!(verdict_o.pop && verdict_o.taken));
  end
endmodule

// File: rtl/brunit_target.sv
module brunit_target #(
  parameter int PC_W  = 16,
  parameter int OFF_W = 9,
  parameter int STEP  = 1
) (
  input  logic [PC_W-1:0]  base_i,
  input  logic [OFF_W-1:0] disp_i,
  input  logic             taken_i,
  output logic [PC_W-1:0]  target_o
);
  logic [PC_W-1:0] disp_ext;
  logic [PC_W-1:0] seq_pc;

  generate
    if (OFF_W < PC_W) begin : g_sext
      assign disp_ext = {{(PC_W-OFF_W){disp_i[OFF_W-1]}}, disp_i};
    end else begin : g_full
      assign disp_ext = disp_i[PC_W-1:0];
    end
  endgenerate

  always_comb begin
    seq_pc   = base_i + PC_W'(STEP);
    target_o = taken_i ? (seq_pc + disp_ext) : seq_pc;
  end
endmodule

// File: rtl/brunit_top.sv
module brunit_top
  import brunit_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int TAG_W = 5,
  parameter logic [TAG_W-1:0] LIST_TAG = 5'd3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic             last_nil_i,
  input  logic [TAG_W-1:0] last_tag_i,
  output logic             fetch_req_o,
  output logic [PC_W-1:0]  fetch_addr_o,
  input  logic [PC_W-1:0]  fetch_data_i,
  output logic             done_o,
  output logic [PC_W-1:0]  next_pc_o,
  output logic             pop_o,
  output logic             illegal_o
);
  cond_e              cond;
  logic [SHORT_W-1:0] disp;
  logic               is_branch, is_long;
  verdict_t           verdict;
  logic [PC_W-1:0]    short_tgt, long_tgt;

  state_e             state_q, state_d;
  logic [PC_W-1:0]    pc_q, pc_d;
  logic               taken_q, taken_d, popc_q, popc_d;
  logic               done_d, pop_d, ill_d, npc_en;
  logic [PC_W-1:0]    npc_d;
  logic               accept;

  brunit_decode i_decode (
    .word_i      (word_i),
    .cond_o      (cond),
    .disp_o      (disp),
    .is_branch_o (is_branch),
    .is_long_o   (is_long)
  );

  brunit_cond #(.TAG_W(TAG_W), .LIST_TAG(LIST_TAG)) i_cond (
    .cond_i    (cond),
    .nil_i     (last_nil_i),
    .tag_i     (last_tag_i),
    .verdict_o (verdict)
  );

  brunit_target #(.PC_W(PC_W), .OFF_W(SHORT_W), .STEP(1)) i_short_tgt (
    .base_i   (pc_i),
    .disp_i   (disp),
    .taken_i  (verdict.taken),
    .target_o (short_tgt)
  );

  brunit_target #(.PC_W(PC_W), .OFF_W(PC_W), .STEP(2)) i_long_tgt (
    .base_i   (pc_q),
    .disp_i   (fetch_data_i),
    .taken_i  (taken_q),
    .target_o (long_tgt)
  );

  // next-state process
  always_comb begin
    accept       = (state_q == S_IDLE) && start_i && is_branch;
    state_d      = state_q;
    pc_d         = pc_q;
    taken_d      = taken_q;
    popc_d       = popc_q;
    done_d       = 1'b0;
    pop_d        = 1'b0;
    ill_d        = 1'b0;
    npc_en       = 1'b0;
    npc_d        = next_pc_o;
    fetch_req_o  = 1'b0;
    fetch_addr_o = pc_q + PC_W'(1);
    unique case (state_q)
      S_IDLE: begin
        if (accept) begin
          if (verdict.bad) begin
            done_d = 1'b1;
            ill_d  = 1'b1;
            npc_en = 1'b1;
            npc_d  = pc_i;
          end else if (is_long) begin
            state_d = S_EXT;
            pc_d    = pc_i;
            taken_d = verdict.taken;
            popc_d  = verdict.pop;
          end else begin
            done_d = 1'b1;
            pop_d  = verdict.pop;
            npc_en = 1'b1;
            npc_d  = short_tgt;
          end
        end
      end
      S_EXT: begin
        fetch_req_o = 1'b1;
        done_d      = 1'b1;
        pop_d       = popc_q;
        npc_en      = 1'b1;
        npc_d       = long_tgt;
        state_d     = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      pc_q      <= '0;
      taken_q   <= 1'b0;
      popc_q    <= 1'b0;
      done_o    <= 1'b0;
      pop_o     <= 1'b0;
      illegal_o <= 1'b0;
      next_pc_o <= '0;
    end else begin
      state_q   <= state_d;
      pc_q      <= pc_d;
      taken_q   <= taken_d;
      popc_q    <= popc_d;
      done_o    <= done_d;
      pop_o     <= pop_d;
      illegal_o <= ill_d;
      if (npc_en) begin
        next_pc_o <= npc_d;
      end
    end
  end

  // R1: a non-branch word from idle is ignored
  p_ignore_other_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && start_i && !is_branch) |=> (!done_o && !fetch_req_o));

  // R2: a short legal branch completes on the next edge
  p_short_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !is_long && !verdict.bad) |=> (done_o && !fetch_req_o));

  // R4: pop and illegal never come together
  p_pop_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_o |-> (done_o && !illegal_o));

  // R5: a long branch fetches the word after the branch
  p_long_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_long && !verdict.bad) |=>
      (fetch_req_o && !done_o && fetch_addr_o == $past(pc_i) + PC_W'(1)));

  // R6: every fetch cycle is followed by completion
  p_fetch_then_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req_o |=> (done_o && !illegal_o));

  // R7: illegal condition holds the pc and fetches nothing
  p_bad_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && verdict.bad) |=>
      (done_o && illegal_o && !pop_o && !fetch_req_o && next_pc_o == $past(pc_i)));

  // R9: no completion two cycles running after a long branch
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(fetch_req_o)) |=> !done_o || $past(start_i));
endmodule

// File: tb/test_brunit_top.sv
module test_brunit_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 22;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] word, pc, fetch_addr, fetch_data, next_pc;
  logic        last_nil, fetch_req, done, pop, illegal;
  logic [4:0]  last_tag;
  logic [15:0] mem_addr, mem_word;
  int          checks = 0, failures = 0;
  bit          finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // model memory: answers only at the expected extension address
  assign fetch_data = (fetch_addr == mem_addr) ? mem_word : 16'hBAD0;

  brunit_top i_brunit_top (
    .clk(clk), .rst_n(rst_n), .start_i(start), .word_i(word), .pc_i(pc),
    .last_nil_i(last_nil), .last_tag_i(last_tag),
    .fetch_req_o(fetch_req), .fetch_addr_o(fetch_addr), .fetch_data_i(fetch_data),
    .done_o(done), .next_pc_o(next_pc), .pop_o(pop), .illegal_o(illegal)
  );

  // {cond[3], disp[9], ext[16], nil[1], tag[5], pc[16], exp_npc[16], exp_pop[1], exp_ill[1]}
  localparam logic [67:0] VEC [0:NVEC-1] = '{
    {3'd0, 9'h000, 16'h0000, 1'b0, 5'd0, 16'h0100, 16'h0101, 1'b0, 1'b0},
    {3'd0, 9'h005, 16'h0000, 1'b0, 5'd0, 16'h0100, 16'h0106, 1'b0, 1'b0},
    {3'd0, 9'h1FD, 16'h0000, 1'b0, 5'd0, 16'h0100, 16'h00FE, 1'b0, 1'b0},
    {3'd1, 9'h010, 16'h0000, 1'b1, 5'd0, 16'h0100, 16'h0111, 1'b0, 1'b0},
    {3'd1, 9'h010, 16'h0000, 1'b0, 5'd0, 16'h0100, 16'h0101, 1'b0, 1'b0},
    {3'd2, 9'h020, 16'h0000, 1'b0, 5'd0, 16'h0100, 16'h0121, 1'b0, 1'b0},
    {3'd2, 9'h020, 16'h0000, 1'b1, 5'd0, 16'h0100, 16'h0101, 1'b0, 1'b0},
    {3'd3, 9'h004, 16'h0000, 1'b1, 5'd0, 16'h0100, 16'h0105, 1'b0, 1'b0},
    {3'd3, 9'h004, 16'h0000, 1'b0, 5'd0, 16'h0100, 16'h0101, 1'b1, 1'b0},
    {3'd4, 9'h004, 16'h0000, 1'b0, 5'd0, 16'h0100, 16'h0105, 1'b0, 1'b0},
    {3'd4, 9'h004, 16'h0000, 1'b1, 5'd0, 16'h0100, 16'h0101, 1'b1, 1'b0},
    {3'd5, 9'h008, 16'h0000, 1'b0, 5'd3, 16'h0100, 16'h0101, 1'b0, 1'b0},
    {3'd5, 9'h008, 16'h0000, 1'b0, 5'd7, 16'h0100, 16'h0109, 1'b0, 1'b0},
    {3'd6, 9'h008, 16'h0000, 1'b0, 5'd3, 16'h0100, 16'h0109, 1'b0, 1'b0},
    {3'd6, 9'h008, 16'h0000, 1'b0, 5'd0, 16'h0100, 16'h0101, 1'b0, 1'b0},
    {3'd7, 9'h008, 16'h0000, 1'b0, 5'd0, 16'h0100, 16'h0100, 1'b0, 1'b1},
    {3'd0, 9'h1FF, 16'h0100, 1'b0, 5'd0, 16'h0200, 16'h0302, 1'b0, 1'b0},
    {3'd1, 9'h1FF, 16'h0100, 1'b0, 5'd0, 16'h0200, 16'h0202, 1'b0, 1'b0},
    {3'd0, 9'h1FF, 16'hFFF0, 1'b0, 5'd0, 16'h0200, 16'h01F2, 1'b0, 1'b0},
    {3'd3, 9'h1FF, 16'h0040, 1'b0, 5'd0, 16'h0200, 16'h0202, 1'b1, 1'b0},
    {3'd0, 9'h0FF, 16'h0000, 1'b0, 5'd0, 16'h0100, 16'h0200, 1'b0, 1'b0},
    {3'd0, 9'h100, 16'h0000, 1'b0, 5'd0, 16'h0100, 16'h0001, 1'b0, 1'b0}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drives one branch and checks its timing and results
  task automatic run_branch(input logic [2:0] cnd, input logic [8:0] dsp,
                            input logic [15:0] ext, input logic nil,
                            input logic [4:0] tag, input logic [15:0] at,
                            input logic [15:0] exp_npc, input logic exp_pop,
                            input logic exp_ill, input string req);
    bit lng;
    lng = (dsp == 9'h1FF) && (cnd != 3'd7);
    @(negedge clk);
    word = {cnd, 4'b1100, dsp}; pc = at; last_nil = nil; last_tag = tag;
    mem_addr = at + 16'd1; mem_word = ext; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (lng) begin
      check(fetch_req === 1'b1 && done === 1'b0, "R5 fetch request", {fetch_req, done}, 2'b10);
      check(fetch_addr === at + 16'd1, "R5 fetch address", fetch_addr, at + 16'd1);
      @(negedge clk);
    end else begin
      check(fetch_req === 1'b0, "R7/R2 no fetch", fetch_req, 0);
    end
    check(done === 1'b1, {req, " done timing R2/R6"}, done, 1);
    check(next_pc === exp_npc, {req, " next pc R2/R3/R6/R10"}, next_pc, exp_npc);
    check(pop === exp_pop, {req, " pop R4"}, pop, exp_pop);
    check(illegal === exp_ill, {req, " illegal R7"}, illegal, exp_ill);
    @(negedge clk);
    check(done === 1'b0 && pop === 1'b0, "R9 single pulse", {done, pop}, 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; word = '0; pc = '0; last_nil = 1'b0;
    last_tag = '0; mem_addr = '0; mem_word = '0;
    repeat (3) @(negedge clk);
    check({done, pop, illegal, fetch_req} === 4'b0, "R8 in reset", {done, pop, illegal, fetch_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({done, pop, illegal, fetch_req} === 4'b0, "R8 after reset", {done, pop, illegal, fetch_req}, 0);

    // table walk: R2 R3 R4 R6 R7 R10
    for (int i = 0; i < NVEC; i++) begin
      run_branch(VEC[i][67:65], VEC[i][64:56], VEC[i][55:40], VEC[i][39],
                 VEC[i][38:34], VEC[i][33:18], VEC[i][17:2], VEC[i][1],
                 VEC[i][0], $sformatf("vec%0d", i));
    end

    // R1: a word with another opcode is ignored
    @(negedge clk);
    word = {3'd0, 4'b0011, 9'h1FF}; pc = 16'h0400; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done === 1'b0 && fetch_req === 1'b0, "R1 other opcode ignored", {done, fetch_req}, 0);
    @(negedge clk);
    check(done === 1'b0, "R1 still no completion", done, 0);

    // R7: illegal code with all-ones displacement does not fetch
    run_branch(3'd7, 9'h1FF, 16'h1234, 1'b1, 5'd0, 16'h0300, 16'h0300, 1'b0, 1'b1, "R7 long-form");
    // R10: wrap at the top of the address space
    run_branch(3'd0, 9'h000, 16'h0000, 1'b0, 5'd0, 16'hFFFF, 16'h0000, 1'b0, 1'b0, "R10 wrap");
    run_branch(3'd0, 9'h1FF, 16'h0003, 1'b0, 5'd0, 16'hFFFF, 16'h0004, 1'b0, 1'b0, "R10 long wrap");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule